// File: doc/BRIEF.md
# Quarter-Duty LCD Plane Sequencer

This block drives a one-third-bias, four-way multiplexed liquid-crystal panel. The panel has NUM_BP backplanes and NUM_FP frontplanes. The block takes a segment word of NUM_BP*NUM_FP bits, one bit per segment. It steps through the backplanes one at a time. For each plane it emits a 2-bit level code, which an analog stage outside the block turns into a voltage. Every backplane period is split into two equal halves of opposite polarity, so each plane pair carries no net DC component over a period.

A chain of identical drivers can share one display. One driver runs as the timing master. It derives its frame timing from the oscillator clock and marks the first cycle of every frame with a one-cycle sync pulse. The other drivers run as slaves. Each slave takes that pulse on its sync input and realigns its own sequence to it. The segment word is captured only when a frame begins, so a new word presented in the middle of a frame never mixes with the one being shown. With the default HALF_DIV of 125, a frame lasts 1000 oscillator cycles, so a 100 kHz oscillator gives about 100 Hz refresh.

Top module: `lcdmux_seq`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, the block is at the first cycle of a frame with an all-zero captured word. Backplane 1 carries code 11 and the other backplanes carry 01. Every frontplane carries 10. In master mode `fsync_out` is 1.
- R2: Backplanes become active strictly in the order 1, 2, 3, 4 and then repeat. Each one is active for 2*HALF_DIV consecutive cycles, so a frame lasts 2*NUM_BP*HALF_DIV cycles. Exactly one backplane is active in any cycle.
- R3: Level codes are 00 for 0, 01 for 1/3, 10 for 2/3 and 11 for full drive. Backplane b (1-based) uses `bp_code[2b-1:2b-2]`. The active backplane carries 11 in the first HALF_DIV cycles of its period and 00 in the second. Every inactive backplane carries 01 in the first half and 10 in the second.
- R4: A frontplane whose segment bit is 1 carries 00 in the first half of the period and 11 in the second. A frontplane whose bit is 0 carries 10 and then 01. Frontplane j (0-based) uses `fp_code[2j+1:2j]`.
- R5: During the period of backplane b (0-based), frontplane j shows bit `j*NUM_BP + b` of the captured word.
- R6: The segment word is captured at the clock edge that begins a frame. Changing `seg_word` at any other time has no effect on `fp_code` until the next frame begins.
- R7: In master mode, `fsync_out` is 1 in exactly the first cycle of each frame and 0 otherwise. In slave mode it stays 0.
- R8: In slave mode, a sync pulse seen while the block is not at the first cycle of a frame moves it to the second cycle of a frame and captures `seg_word` at the same edge. A pulse seen while the block is already at the first cycle of a frame leaves the sequence and the captured word unchanged.
- R9: In master mode, `fsync_in` has no effect on the sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator-derived clock |
| rst | input | 1 | Synchronous active-high reset |
| is_master | input | 1 | 1: generate frame timing; 0: follow fsync_in |
| fsync_in | input | 1 | Frame-sync pulse from the master (slave mode) |
| seg_word | input | NUM_BP*NUM_FP | Segment bits, bit j*NUM_BP+b for frontplane j under backplane b |
| bp_code | output | 2*NUM_BP | Backplane level codes, 2 bits each |
| fp_code | output | 2*NUM_FP | Frontplane level codes, 2 bits each |
| fsync_out | output | 1 | One-cycle frame-start pulse (master mode) |

## Verification
The bench keeps the default plane counts of 4 backplanes and 32 frontplanes. It sets HALF_DIV to 2, so a frame is only 16 cycles long. With frames that short, every half-period boundary, every backplane hand-over and every frame wrap can be compared cycle by cycle across several frames. The same short frame lets the bench place a slave sync pulse at a chosen frame position, including the frame-start cycle itself, and it lets a mid-frame word change be followed through to the next frame.

// File: rtl/lcdmux_pkg.sv
package lcdmux_pkg;

    typedef enum logic [1:0] {
        LVL_ZERO      = 2'b00,
        LVL_THIRD     = 2'b01,
        LVL_TWO_THIRD = 2'b10,
        LVL_FULL      = 2'b11
    } lvl_e;

    typedef struct packed {
        logic second_half;
        logic at_start;
        logic load_word;
    } phase_t;

    function automatic lvl_e bp_level(input logic active, input logic second_half);
        if (active) return second_half ? LVL_ZERO : LVL_FULL;
        return second_half ? LVL_TWO_THIRD : LVL_THIRD;
    endfunction

    function automatic lvl_e fp_level(input logic seg_on, input logic second_half);
        if (seg_on) return second_half ? LVL_FULL : LVL_ZERO;
        return second_half ? LVL_THIRD : LVL_TWO_THIRD;
    endfunction

endpackage

// File: rtl/lcdmux_timebase.sv
module lcdmux_timebase
    import lcdmux_pkg::*;
#(
    parameter int NUM_BP   = 4,
    parameter int HALF_DIV = 125
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              is_master,
    input  logic                              fsync_in,
    output logic [$clog2(NUM_BP)-1:0]         bp_sel,
    output phase_t                            phase,
    output logic                              fsync_out
);
    localparam int BP_W  = $clog2(NUM_BP);
    localparam int DIV_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [DIV_W-1:0] DIV_MAX = DIV_W'(HALF_DIV - 1);
    localparam logic [BP_W-1:0]  BP_MAX  = BP_W'(NUM_BP - 1);
    // position one cycle after the frame start
    localparam logic [DIV_W-1:0] JMP_DIV  = (HALF_DIV > 1) ? DIV_W'(1) : '0;
    localparam logic             JMP_HALF = (HALF_DIV == 1);

    logic [DIV_W-1:0] div_q, div_d;
    logic             half_q, half_d;
    logic [BP_W-1:0]  bp_q, bp_d;
    logic             at_start, wrap_to_start, resync;

    assign at_start      = (div_q == '0) && !half_q && (bp_q == '0);
    assign wrap_to_start = (div_q == DIV_MAX) && half_q && (bp_q == BP_MAX);
    assign resync        = !is_master && fsync_in && !at_start;

    always_comb begin
        div_d  = div_q;
        half_d = half_q;
        bp_d   = bp_q;
        if (resync) begin
            div_d  = JMP_DIV;
            half_d = JMP_HALF;
            bp_d   = '0;
        end else if (div_q == DIV_MAX) begin
            div_d = '0;
            if (half_q) begin
                half_d = 1'b0;
                bp_d   = (bp_q == BP_MAX) ? '0 : bp_q + 1'b1;
            end else begin
                half_d = 1'b1;
            end
        end else begin
            div_d = div_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            div_q  <= '0;
            half_q <= 1'b0;
            bp_q   <= '0;
        end else begin
            div_q  <= div_d;
            half_q <= half_d;
            bp_q   <= bp_d;
        end
    end

    assign bp_sel            = bp_q;
    assign phase.second_half = half_q;
    assign phase.at_start    = at_start;
    assign phase.load_word   = wrap_to_start || resync;
    assign fsync_out         = is_master && at_start;

endmodule

// File: rtl/lcdmux_frame_latch.sv
module lcdmux_frame_latch #(
    parameter int WORD_W = 128
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [WORD_W-1:0] word_in,
    output logic [WORD_W-1:0] word_out
);
    always_ff @(posedge clk) begin
        if (rst)       word_out <= '0;
        else if (load) word_out <= word_in;
    end
endmodule

// File: rtl/lcdmux_plane_drive.sv
module lcdmux_plane_drive
    import lcdmux_pkg::*;
#(
    parameter int NUM_BP = 4,
    parameter int NUM_FP = 32
) (
    input  logic [$clog2(NUM_BP)-1:0]  bp_sel,
    input  logic                       second_half,
    input  logic [NUM_BP*NUM_FP-1:0]   word,
    output logic [2*NUM_BP-1:0]        bp_code,
    output logic [2*NUM_FP-1:0]        fp_code
);
    localparam int BP_W = $clog2(NUM_BP);

    for (genvar b = 0; b < NUM_BP; b++) begin : g_bp
        assign bp_code[2*b +: 2] = bp_level(bp_sel == BP_W'(b), second_half);
    end

    for (genvar j = 0; j < NUM_FP; j++) begin : g_fp
        logic [NUM_BP-1:0] group;
        assign group             = word[j*NUM_BP +: NUM_BP];
        assign fp_code[2*j +: 2] = fp_level(group[bp_sel], second_half);
    end
endmodule

// File: rtl/lcdmux_seq.sv
module lcdmux_seq
    import lcdmux_pkg::*;
#(
    parameter int NUM_BP   = 4,
    parameter int NUM_FP   = 32,
    parameter int HALF_DIV = 125
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      is_master,
    input  logic                      fsync_in,
    input  logic [NUM_BP*NUM_FP-1:0]  seg_word,
    output logic [2*NUM_BP-1:0]       bp_code,
    output logic [2*NUM_FP-1:0]       fp_code,
    output logic                      fsync_out
);
    localparam int WORD_W = NUM_BP * NUM_FP;
    localparam int BP_W   = $clog2(NUM_BP);

    logic [BP_W-1:0]   bp_sel;
    phase_t            phase;
    logic [WORD_W-1:0] shown_word;

    lcdmux_timebase #(.NUM_BP(NUM_BP), .HALF_DIV(HALF_DIV)) u_timebase (
        .clk       (clk),
        .rst       (rst),
        .is_master (is_master),
        .fsync_in  (fsync_in),
        .bp_sel    (bp_sel),
        .phase     (phase),
        .fsync_out (fsync_out)
    );

    lcdmux_frame_latch #(.WORD_W(WORD_W)) u_latch (
        .clk      (clk),
        .rst      (rst),
        .load     (phase.load_word),
        .word_in  (seg_word),
        .word_out (shown_word)
    );

    lcdmux_plane_drive #(.NUM_BP(NUM_BP), .NUM_FP(NUM_FP)) u_drive (
        .bp_sel      (bp_sel),
        .second_half (phase.second_half),
        .word        (shown_word),
        .bp_code     (bp_code),
        .fp_code     (fp_code)
    );
endmodule

// File: rtl/lcdmux_seq_chk.sv
module lcdmux_seq_chk #(
    parameter int NUM_BP   = 4,
    parameter int NUM_FP   = 32,
    parameter int HALF_DIV = 125
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 is_master,
    input logic                 fsync_in,
    input logic [2*NUM_BP-1:0]  bp_code,
    input logic [2*NUM_FP-1:0]  fp_code,
    input logic                 fsync_out
);
    logic [NUM_BP-1:0] bp_driven, bp_pol;
    logic [NUM_FP-1:0] fp_pol;

    for (genvar b = 0; b < NUM_BP; b++) begin : g_b
        assign bp_driven[b] = bp_code[2*b+1] == bp_code[2*b];
        assign bp_pol[b]    = bp_code[2*b];
    end
    for (genvar j = 0; j < NUM_FP; j++) begin : g_f
        assign fp_pol[j] = fp_code[2*j];
    end

    AST_ONE_DRIVEN: assert property (@(posedge clk) disable iff (rst)
        $countones(bp_driven) == 1); // R2

    AST_PHASE_POLARITY: assert property (@(posedge clk) disable iff (rst)
        ((&bp_pol) || !(|bp_pol)) && ((&fp_pol) || !(|fp_pol)) && (bp_pol[0] != fp_pol[0])); // R4

    AST_SYNC_ON_FIRST: assert property (@(posedge clk) disable iff (rst)
        fsync_out |-> bp_code[1:0] == 2'b11); // R7

    AST_SLAVE_SILENT: assert property (@(posedge clk) disable iff (rst)
        !is_master |-> !fsync_out); // R7

    AST_SLAVE_LOCK: assert property (@(posedge clk) disable iff (rst)
        (!is_master && fsync_in) |=> bp_driven[0]); // R8

    AST_FRAME_HOLD: assert property (@(posedge clk) disable iff (rst)
        ($stable(bp_code) && !$past(fsync_in)) |-> $stable(fp_code)); // R6
endmodule

bind lcdmux_seq lcdmux_seq_chk #(.NUM_BP(NUM_BP), .NUM_FP(NUM_FP), .HALF_DIV(HALF_DIV)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .is_master (is_master),
    .fsync_in  (fsync_in),
    .bp_code   (bp_code),
    .fp_code   (fp_code),
    .fsync_out (fsync_out)
);

// File: tb/test_lcdmux_seq.sv
module test_lcdmux_seq;
    localparam int NB = 4;
    localparam int NF = 32;
    localparam int H  = 2;
    localparam int FRAME = 2 * NB * H;
    localparam int W  = NB * NF;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          is_master = 1'b1;
    logic          fsync_in = 1'b0;
    logic [W-1:0]  seg_word = '0;
    logic [2*NB-1:0] bp_code;
    logic [2*NF-1:0] fp_code;
    logic          fsync_out;

    int n_chk = 0;
    int n_bad = 0;
    int pos = 0;
    logic [W-1:0] cur_word = '0;

    always #10 clk = ~clk;

    lcdmux_seq #(.NUM_BP(NB), .NUM_FP(NF), .HALF_DIV(H)) i_lcdmux_seq (
        .clk(clk), .rst(rst), .is_master(is_master), .fsync_in(fsync_in),
        .seg_word(seg_word), .bp_code(bp_code), .fp_code(fp_code), .fsync_out(fsync_out)
    );

    function automatic logic [2*NB-1:0] exp_bp(int p);
        logic [2*NB-1:0] v;
        int act = p / (2*H);
        logic sec = ((p / H) % 2) == 1;
        for (int b = 0; b < NB; b++)
            v[2*b +: 2] = (b == act) ? (sec ? 2'b00 : 2'b11) : (sec ? 2'b10 : 2'b01);
        return v;
    endfunction

    function automatic logic [2*NF-1:0] exp_fp(int p, logic [W-1:0] w);
        logic [2*NF-1:0] v;
        int act = p / (2*H);
        logic sec = ((p / H) % 2) == 1;
        for (int j = 0; j < NF; j++)
            v[2*j +: 2] = w[j*NB + act] ? (sec ? 2'b11 : 2'b00) : (sec ? 2'b01 : 2'b10);
        return v;
    endfunction

    task automatic chk(string tag);
        logic [2*NB-1:0] eb = exp_bp(pos);
        logic [2*NF-1:0] ef = exp_fp(pos, cur_word);
        logic es = is_master && (pos == 0);
        n_chk++;
        if (bp_code !== eb || fp_code !== ef || fsync_out !== es) begin
            n_bad++;
            $display("FAIL %s pos=%0d bp=%h/%h fp=%h/%h fs=%b/%b (actual/expected)",
                     tag, pos, bp_code, eb, fp_code, ef, fsync_out, es);
        end
    endtask

    // advance one clock; model follows R2, R6, R8, R9
    task automatic step();
        if (!is_master && fsync_in && pos != 0) begin
            pos = 1;
            cur_word = seg_word;
        end else begin
            pos = (pos + 1) % FRAME;
            if (pos == 0) cur_word = seg_word;
        end
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset(logic master);
        @(negedge clk);
        rst = 1'b1;
        is_master = master;
        fsync_in = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        pos = 0;
        cur_word = '0;
    endtask

    task automatic t_reset();
        seg_word = {W{1'b1}};
        do_reset(1'b1);
        chk("R1");
    endtask

    task automatic t_sequence();
        seg_word = '0;
        do_reset(1'b1);
        for (int k = 0; k < 2*FRAME; k++) begin
            step();
            chk("R2 R3 R7");
        end
    endtask

    task automatic t_patterns();
        logic [W-1:0] pats [4];
        pats[0] = {W{1'b1}};
        pats[1] = {(W/8){8'hA5}};
        pats[2] = '0; pats[2][7*NB + 2] = 1'b1;
        pats[3] = {(W/4){4'b0001}};
        do_reset(1'b1);
        for (int p = 0; p < 4; p++) begin
            seg_word = pats[p];
            while (pos != FRAME - 1) step();
            for (int k = 0; k < FRAME; k++) begin
                step();
                chk("R4 R5");
            end
        end
    endtask

    task automatic t_tearing();
        seg_word = {(W/8){8'h3C}};
        do_reset(1'b1);
        while (pos != FRAME - 1) step();
        step();
        for (int k = 0; k < 5; k++) step();
        seg_word = ~seg_word;
        for (int k = 0; k < FRAME; k++) begin
            step();
            chk("R6");
        end
    endtask

    task automatic t_slave();
        do_reset(1'b0);
        chk("R7");
        for (int k = 0; k < 5; k++) begin
            step();
            chk("R7");
        end
        seg_word = {(W/8){8'h96}};
        fsync_in = 1'b1;
        step();
        fsync_in = 1'b0;
        chk("R8");
        for (int k = 0; k < FRAME; k++) begin
            step();
            chk("R8");
        end
        while (pos != 0) step();
        seg_word = {(W/8){8'h0F}};
        fsync_in = 1'b1;
        step();
        fsync_in = 1'b0;
        chk("R8");
    endtask

    task automatic t_master_ignores();
        seg_word = {(W/8){8'h5A}};
        do_reset(1'b1);
        for (int k = 0; k < 5; k++) step();
        fsync_in = 1'b1;
        step();
        fsync_in = 1'b0;
        for (int k = 0; k < FRAME + 3; k++) begin
            chk("R9");
            step();
        end
    endtask

    initial begin
        #(200000 * 20);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        t_reset();
        t_sequence();
        t_patterns();
        t_tearing();
        t_slave();
        t_master_ignores();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule